// File: doc/BRIEF.md
# Debug Port Acquisition Window Controller

This block decides whether the two-wire serial debug port of a chip may be claimed after reset. Two candidate pin pairs, each made of one debug clock line and one data line, are watched from the fixed-frequency system clock. A short acquisition window opens at the release of reset. If enough debug clock activity appears early, the window is stretched to a much longer deadline, which is still counted from reset. Inside the open window, each pair shifts its sampled data bits into a sliding register and compares the register against a parameterized acquire key.

The first pair to present the key is granted the port. Its index is latched, and the port-acquired and trace-enable outputs rise together. When the window runs out without a grant, a sticky closed flag is set and all later key traffic is ignored until the next reset. A security enable input, driven from a persistent setting, can refuse acquisition outright. The window timing is given in microseconds and converted with a cycles-per-microsecond parameter.

Top module: `dbg_acq_window_ctrl`

## Requirements
- R1: With fewer than EDGE_NEED (default 8) debug clock rising edges seen inside the first INIT_US×CYC_PER_US system cycles after reset, `window_closed` stays 0 after INIT_US×CYC_PER_US−1 clock edges and is 1 after INIT_US×CYC_PER_US edges.
- R2: When the EDGE_NEED-th rising edge, counted over both pairs' clock lines, is seen inside the initial window, `window_extended` goes to 1 and stays 1, and the window stays open.
- R3: An extended window that expires without a grant sets `window_closed` after exactly EXT_US×CYC_PER_US clock edges from reset. It is still 0 one edge earlier.
- R4: The port is granted when the last KEY_W data bits sampled on one pair equal KEY, with the bits taken LSB first (first bit = KEY bit 0). Any number of leading bits before the key are tolerated, and a key with a flipped bit is not granted.
- R5: `selected_pair` is 0 for pair A (`pa_*`) and 1 for pair B (`pb_*`). The first pair to complete the key wins. On a tie in the same cycle pair A wins, and the losing pair is ignored afterwards.
- R6: `trace_en` is 1 in exactly the cycles where `acquired` is 1.
- R7: While `sec_enable` is 0, `acquired` does not rise, whatever the window or key state.
- R8: `window_closed` is sticky until reset, and a full valid key sent after closure does not set `acquired`.
- R9: During reset all outputs are 0.
- R10: Once `acquired` is 1, it and `selected_pair` hold their values until reset, and the window never closes.
- R11: The debug clock and data inputs pass two synchronizer flops. A data bit is taken at the synchronized rising edge of its pair's clock, so data changes while the debug clock is high have no effect. When a key's final clock rise is driven before system edge k, `acquired` is 0 after edge k+2 and 1 after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_enable | input | 1 | Security permission; 0 refuses acquisition |
| pa_clk | input | 1 | Pair A debug clock (asynchronous) |
| pa_dio | input | 1 | Pair A debug data, input side |
| pb_clk | input | 1 | Pair B debug clock (asynchronous) |
| pb_dio | input | 1 | Pair B debug data, input side |
| acquired | output | 1 | Port granted (sticky) |
| selected_pair | output | 1 | Granted pair: 0 = A, 1 = B |
| window_extended | output | 1 | Early activity stretched the window (sticky) |
| window_closed | output | 1 | Window expired without a grant (sticky) |
| trace_en | output | 1 | Trace output enable, follows the grant |

## Verification
The assertions assume that `sec_enable` is a level that stays steady for the whole test. They also assume that each debug clock high or low phase lasts at least one system cycle, so the synchronizers see every edge. The stimulus holds every debug clock level for a full system cycle and changes the data only at the rising edge or while the clock is high. It changes `sec_enable` only while reset is asserted. With this stimulus, the bit count the bench expects matches the bit count the design samples.

// File: rtl/dap_acq_pkg.sv
// Shared definitions for the debug port acquisition controller.
// Assumes two candidate pin pairs; the window state encoding is private to the timer.
package dap_acq_pkg;
    localparam int NUM_PAIRS = 2;

    typedef enum logic [1:0] {
        WIN_INIT = 2'd0,
        WIN_EXT  = 2'd1,
        WIN_SHUT = 2'd2
    } win_state_t;
endpackage

// File: rtl/dap_pin_sync.sv
// Brings one debug clock/data pair into the system clock domain.
// Assumes each debug clock phase is held for at least one system cycle.
// Produces a one-cycle strobe on a synchronized rising edge, plus the data sampled in step with it.
module dap_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dbg_clk,
    input  logic dbg_dat,
    output logic bit_strobe,
    output logic bit_val
);
    logic [STAGES-1:0] clk_sr;
    logic [STAGES-1:0] dat_sr;
    logic              clk_prev;

    // synchronizer chains for clock and data, equal depth so they stay aligned
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sr   <= '0;
            dat_sr   <= '0;
            clk_prev <= 1'b0;
        end else begin
            clk_sr   <= {clk_sr[STAGES-2:0], dbg_clk};
            dat_sr   <= {dat_sr[STAGES-2:0], dbg_dat};
            clk_prev <= clk_sr[STAGES-1];
        end
    end

    // rising edge of the synchronized debug clock; the data bit comes from the same stage
    always_comb begin
        bit_strobe = clk_sr[STAGES-1] & ~clk_prev;
        bit_val    = dat_sr[STAGES-1];
    end
endmodule

// File: rtl/dap_key_shift.sv
// Sliding key register for one pin pair. Bits enter LSB first at the top.
// Assumes the shift enable is removed once the window shuts or the port is granted.
// Raises key_hit when at least KEY_W bits have arrived and the last KEY_W equal KEY.
module dap_key_shift #(
    parameter int               KEY_W = 32,
    parameter logic [KEY_W-1:0] KEY   = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic bit_strobe,
    input  logic bit_val,
    output logic key_hit
);
    localparam int              CNT_W = $clog2(KEY_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(KEY_W);

    logic [KEY_W-1:0] shreg;
    logic [CNT_W-1:0] fill;

    // shift a new bit in at the MSB so the first bit ends at bit 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            fill  <= '0;
        end else if (shift_en && bit_strobe) begin
            shreg <= {bit_val, shreg[KEY_W-1:1]};
            if (fill != FULL) fill <= fill + 1'b1;
        end
    end

    // match only once the register holds real bits
    always_comb key_hit = (fill == FULL) && (shreg == KEY);
endmodule

// File: rtl/dap_window_timer.sv
// Times the acquisition window from reset release.
// Assumes edge_seen is a single-cycle pulse per synchronized debug clock rise.
// Opens a short initial window and stretches it when EDGE_NEED edges arrive early.
// Shuts the window at its deadline unless the port is held.
module dap_window_timer
    import dap_acq_pkg::*;
#(
    parameter int INIT_CYC  = 400,
    parameter int EXT_CYC   = 20000,
    parameter int EDGE_NEED = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_seen,
    input  logic hold,
    output logic win_open,
    output logic extended,
    output logic closed
);
    localparam int CW = $clog2(EXT_CYC + 1);
    localparam int EW = $clog2(EDGE_NEED + 1);
    localparam logic [CW-1:0] INIT_LAST = CW'(INIT_CYC - 1);
    localparam logic [CW-1:0] EXT_LAST  = CW'(EXT_CYC - 1);
    localparam logic [CW-1:0] EXT_SAT   = CW'(EXT_CYC);
    localparam logic [EW-1:0] EDGE_LAST = EW'(EDGE_NEED - 1);
    localparam logic [EW-1:0] EDGE_SAT  = EW'(EDGE_NEED);

    win_state_t    state, state_nx;
    logic [CW-1:0] cyc;
    logic [EW-1:0] edges;
    logic          ext_q;

    // cycles since reset, saturating at the long deadline
    always_ff @(posedge clk) begin
        if (!rst_n)              cyc <= '0;
        else if (cyc != EXT_SAT) cyc <= cyc + 1'b1;
    end

    // early debug clock edges, counted only while the initial window runs
    always_ff @(posedge clk) begin
        if (!rst_n)
            edges <= '0;
        else if (state == WIN_INIT && edge_seen && edges != EDGE_SAT)
            edges <= edges + 1'b1;
    end

    // window state transitions
    always_comb begin
        state_nx = state;
        case (state)
            WIN_INIT: begin
                if (edge_seen && edges == EDGE_LAST)
                    state_nx = WIN_EXT;
                else if (cyc == INIT_LAST && !hold)
                    state_nx = WIN_SHUT;
            end
            WIN_EXT: begin
                if (cyc == EXT_LAST && !hold)
                    state_nx = WIN_SHUT;
            end
            default: state_nx = WIN_SHUT;
        endcase
    end

    // state register and the sticky extension flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WIN_INIT;
            ext_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == WIN_INIT && state_nx == WIN_EXT) ext_q <= 1'b1;
        end
    end

    // decoded window status
    always_comb begin
        win_open = (state != WIN_SHUT);
        closed   = (state == WIN_SHUT);
        extended = ext_q;
    end
endmodule

// File: rtl/dbg_acq_window_ctrl.sv
// Debug port acquisition window controller, top level.
// Assumes the debug pins are asynchronous to clk and that sec_enable is a quasi-static level.
// Grants the port to the first pin pair that shifts in KEY inside the open window.
module dbg_acq_window_ctrl
    import dap_acq_pkg::*;
#(
    parameter int               CYC_PER_US  = 50,
    parameter int               INIT_US     = 8,
    parameter int               EXT_US      = 400,
    parameter int               EDGE_NEED   = 8,
    parameter int               SYNC_STAGES = 2,
    parameter int               KEY_W       = 32,
    parameter logic [KEY_W-1:0] KEY         = 32'h6D1B_E4C5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_enable,
    input  logic pa_clk,
    input  logic pa_dio,
    input  logic pb_clk,
    input  logic pb_dio,
    output logic acquired,
    output logic selected_pair,
    output logic window_extended,
    output logic window_closed,
    output logic trace_en
);
    localparam int INIT_CYC = INIT_US * CYC_PER_US;
    localparam int EXT_CYC  = EXT_US * CYC_PER_US;

    logic [NUM_PAIRS-1:0] pin_clk, pin_dat, strobe, bitv, hit;
    logic                 win_open, shift_en;
    logic                 acq_q, sel_q;

    assign pin_clk = {pb_clk, pa_clk};
    assign pin_dat = {pb_dio, pa_dio};

    // one synchronizer and key register per pin pair
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        dap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .dbg_clk   (pin_clk[p]),
            .dbg_dat   (pin_dat[p]),
            .bit_strobe(strobe[p]),
            .bit_val   (bitv[p])
        );
        dap_key_shift #(.KEY_W(KEY_W), .KEY(KEY)) u_key (
            .clk       (clk),
            .rst_n     (rst_n),
            .shift_en  (shift_en),
            .bit_strobe(strobe[p]),
            .bit_val   (bitv[p]),
            .key_hit   (hit[p])
        );
    end

    dap_window_timer #(
        .INIT_CYC (INIT_CYC),
        .EXT_CYC  (EXT_CYC),
        .EDGE_NEED(EDGE_NEED)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_seen(|strobe),
        .hold     (acq_q),
        .win_open (win_open),
        .extended (window_extended),
        .closed   (window_closed)
    );

    // key bits count only while the window is open, unclaimed and permitted
    always_comb shift_en = win_open && !acq_q && sec_enable;

    // grant latch: first matching pair wins, pair A on a tie
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_q <= 1'b0;
            sel_q <= 1'b0;
        end else if (!acq_q && win_open && sec_enable && (|hit)) begin
            acq_q <= 1'b1;
            sel_q <= ~hit[0];
        end
    end

    // outputs; trace follows the grant in the same cycle
    always_comb begin
        acquired      = acq_q;
        selected_pair = sel_q;
        trace_en      = acq_q;
    end
endmodule

// File: rtl/dap_acq_checker.sv
// Temporal checks on the acquisition controller, attached by bind.
// Assumes sec_enable is steady and reset is synchronous active-low.
module dap_acq_checker #(
    parameter int INIT_CYC = 400
) (
    input logic clk,
    input logic rst_n,
    input logic sec_enable,
    input logic acquired,
    input logic selected_pair,
    input logic window_extended,
    input logic window_closed
);
    localparam int CW = $clog2(INIT_CYC + 2);
    localparam logic [CW-1:0] SAT = CW'(INIT_CYC + 1);

    logic [CW-1:0] since_rst;

    // clock edges since reset, saturating just past the initial window
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != SAT) since_rst <= since_rst + 1'b1;
    end

    a_r8_closed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        window_closed |=> window_closed);

    a_r8_no_grant_after_close: assert property (@(posedge clk) disable iff (!rst_n)
        (window_closed && !acquired) |=> !acquired);

    a_r10_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        acquired |=> (acquired && $stable(selected_pair)));

    a_r7_security_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_enable && !acquired) |=> !acquired);

    a_r2_extend_early: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(window_extended) |-> (since_rst <= CW'(INIT_CYC)));

    a_r2_extend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        window_extended |=> window_extended);

    a_r5_idle_select: assert property (@(posedge clk) disable iff (!rst_n)
        !acquired |-> !selected_pair);
endmodule

bind dbg_acq_window_ctrl dap_acq_checker #(.INIT_CYC(INIT_CYC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sec_enable     (sec_enable),
    .acquired       (acquired),
    .selected_pair  (selected_pair),
    .window_extended(window_extended),
    .window_closed  (window_closed)
);

// File: tb/tb_dbg_acq_window_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_acq_window_ctrl;
    localparam int          CPU  = 4;
    localparam int          INIT = 8 * CPU;
    localparam int          EXT  = 400 * CPU;
    localparam logic [31:0] KEYV = 32'h6D1B_E4C5;

    logic clk = 1'b0;
    logic rst_n, sec_enable, pa_clk, pa_dio, pb_clk, pb_dio;
    logic acquired, selected_pair, window_extended, window_closed, trace_en;

    int n_vec = 0, n_bad = 0, tcount = 0;
    bit done = 0;

    dbg_acq_window_ctrl #(.CYC_PER_US(CPU), .KEY(KEYV)) dut (
        .clk(clk), .rst_n(rst_n), .sec_enable(sec_enable),
        .pa_clk(pa_clk), .pa_dio(pa_dio), .pb_clk(pb_clk), .pb_dio(pb_dio),
        .acquired(acquired), .selected_pair(selected_pair),
        .window_extended(window_extended), .window_closed(window_closed),
        .trace_en(trace_en)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic       sec;
        logic [1:0] mask;
        logic [7:0] delay;
        logic [3:0] garb;
        logic       bad;
        logic       e_acq;
        logic       e_sel;
        logic       e_ext;
        logic       e_cls;
    } vec_t;

    // sec, pair mask, delay, leading bits, corrupt key, expected acq/sel/ext/closed
    localparam vec_t VECS [0:5] = '{
        '{1'b1, 2'b01, 8'd0,  4'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b1, 2'b10, 8'd0,  4'd5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b1, 2'b01, 8'd0,  4'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        '{1'b0, 2'b01, 8'd0,  4'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        '{1'b1, 2'b01, 8'd40, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b1, 2'b10, 8'd2,  4'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            tcount++;
        end
    endtask

    task automatic tick_to(input int t);
        while (tcount < t) tick(1);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic sec);
        @(negedge clk);
        rst_n = 1'b0; sec_enable = sec;
        pa_clk = 0; pa_dio = 0; pb_clk = 0; pb_dio = 0;
        tick(3);
        rst_n = 1'b1;
        tcount = 0;
    endtask

    // one bit: data and clock rise together, clock high one cycle, low one cycle
    task automatic send_bit(input logic [1:0] mask, input logic b, input logic glitch);
        if (mask[0]) begin pa_dio = b; pa_clk = 1; end
        if (mask[1]) begin pb_dio = b; pb_clk = 1; end
        tick(1);
        if (glitch) begin
            if (mask[0]) pa_dio = ~b;
            if (mask[1]) pb_dio = ~b;
        end
        pa_clk = 0; pb_clk = 0;
        tick(1);
    endtask

    task automatic send_word(input logic [1:0] mask, input logic [31:0] w,
                             input int nbits, input logic glitch);
        for (int i = 0; i < nbits; i++) send_bit(mask, w[i], glitch);
    endtask

    task automatic check_all(input string tag, input int a, input int s, input int e, input int c);
        check({tag, " R4 acquired"}, int'(acquired), a);
        check({tag, " R5 selected_pair"}, int'(selected_pair), s);
        check({tag, " R2 window_extended"}, int'(window_extended), e);
        check({tag, " R8 window_closed"}, int'(window_closed), c);
        check({tag, " R6 trace_en"}, int'(trace_en), a);
    endtask

    initial begin
        #5_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // table-driven scenarios, judged well past the long deadline
        for (int v = 0; v < 6; v++) begin
            do_reset(VECS[v].sec);
            tick(int'(VECS[v].delay));
            for (int g = 0; g < int'(VECS[v].garb); g++) send_bit(VECS[v].mask, g[0], 1'b0);
            send_word(VECS[v].mask, KEYV ^ {31'd0, VECS[v].bad}, 32, 1'b0);
            tick_to(EXT + 100);
            check_all($sformatf("vec%0d R3 R7", v), VECS[v].e_acq, VECS[v].e_sel,
                      VECS[v].e_ext, VECS[v].e_cls);
        end

        // R9: outputs during reset
        @(negedge clk);
        rst_n = 0;
        tick(2);
        check_all("R9 reset", 0, 0, 0, 0);

        // R1: no activity, exact closing edge; R8: late key ignored
        do_reset(1'b1);
        tick_to(INIT - 1);
        check("R1 closed before edge", int'(window_closed), 0);
        tick(1);
        check("R1 closed at edge", int'(window_closed), 1);
        send_word(2'b01, KEYV, 32, 1'b0);
        tick(6);
        check("R8 late key ignored", int'(acquired), 0);
        check("R8 closed sticky", int'(window_closed), 1);

        // R1/R2 boundary: seven edges are not enough
        do_reset(1'b1);
        send_word(2'b01, 32'h55, 7, 1'b0);
        tick_to(INIT + 8);
        check("R2 seven edges no extend", int'(window_extended), 0);
        check("R1 seven edges closes", int'(window_closed), 1);

        // R2/R3: eight edges extend, then exact long deadline
        do_reset(1'b1);
        send_word(2'b10, 32'hAA, 8, 1'b0);
        tick_to(INIT + 8);
        check("R2 eight edges extend", int'(window_extended), 1);
        check("R2 window open", int'(window_closed), 0);
        tick_to(EXT - 1);
        check("R3 open before deadline", int'(window_closed), 0);
        tick(1);
        check("R3 closed at deadline", int'(window_closed), 1);
        check("R2 extend held", int'(window_extended), 1);

        // R11/R6: grant latency from the final debug clock rise
        do_reset(1'b1);
        send_word(2'b01, KEYV, 31, 1'b0);
        pa_dio = KEYV[31]; pa_clk = 1;
        tick(3);
        check("R11 not yet granted", int'(acquired), 0);
        check("R6 trace off", int'(trace_en), 0);
        tick(1);
        pa_clk = 0;
        check("R11 granted", int'(acquired), 1);
        check("R6 trace with grant", int'(trace_en), 1);

        // R5/R10: A first, then B ignored
        do_reset(1'b1);
        send_word(2'b01, KEYV, 32, 1'b0);
        tick(4);
        send_word(2'b10, KEYV, 32, 1'b0);
        tick(4);
        check_all("R10 A then B", 1, 0, 1, 0);

        // R5: B first, then A ignored
        do_reset(1'b1);
        send_word(2'b10, KEYV, 32, 1'b0);
        tick(4);
        send_word(2'b01, KEYV, 32, 1'b0);
        tick(4);
        check_all("R5 B then A", 1, 1, 1, 0);

        // R5: tie resolved toward pair A
        do_reset(1'b1);
        send_word(2'b11, KEYV, 32, 1'b0);
        tick(4);
        check_all("R5 tie", 1, 0, 1, 0);

        // R11: data changes while the clock is high are ignored
        do_reset(1'b1);
        send_word(2'b10, KEYV, 32, 1'b1);
        tick(4);
        check_all("R11 glitch data", 1, 1, 1, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule